// File: doc/BRIEF.md
# Modulo Timer Counter with Center-Aligned Mode

This block is the time base shared by the channels of a timer. A 16-bit counter advances once per prescaler period. The prescaler divides the system clock by a power of two, and the counter runs only while the clock-select input is non-zero. In up mode the counter climbs to a programmable terminal value and wraps to zero. In center mode it climbs to the terminal value, turns, and descends to zero, so the count is symmetric about the terminal value. A terminal setting of zero selects the full 16-bit range.

The block reports three events, each as a one-cycle pulse that appears in the same cycle as the new count:

- a tick for every advance;
- a hit when the count steps up from one below the terminal value to the terminal value;
- an overflow when the count arrives at zero by wrapping or by descending.

Channel logic uses the hit and the tick to load buffered compare values. Writing the counter clears the count and the prescaler. All pins are plain control and status signals, with no handshake.

Top module: `modtmr_top`

## Requirements
- R1: During and after reset `count` is 0x0000, and `tick`, `top_hit` and `overflow` are 0.
- R2: While `clk_sel` is 2'b00, `count` and the internal prescaler hold their values and `tick` stays 0. The values 2'b01, 2'b10 and 2'b11 all enable counting.
- R3: With counting enabled, the counter advances once every 2^`div_sel` clock cycles. `tick` is high for exactly the one cycle in which the new count first appears.
- R4: With `center_en` low, each advance adds one to the count. An advance taken from the terminal value sets the count to 0x0000.
- R5: In up mode, `overflow` pulses together with the tick that wraps the count from the terminal value to 0x0000.
- R6: With `center_en` high, the count rises by one per advance up to the terminal value, then falls by one per advance to 0x0000, then rises again.
- R7: In center mode, `overflow` pulses with the tick on which the count reaches 0x0000 while falling.
- R8: `top_hit` pulses with the tick on which the count steps upward from terminal-1 to the terminal value. It does not pulse on any other tick.
- R9: The terminal value is `modulo`, except that `modulo` = 0 selects 0xFFFF. In that case the count reaches 0xFFFF and `top_hit` pulses on the step from 0xFFFE to 0xFFFF.
- R10: A cycle with `count_wr` high sets the count and the prescaler to zero and sets the direction to upward. The first tick that follows comes a full 2^`div_sel` cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 2 | 2'b00 stops the counter; any other value enables it |
| div_sel | input | 3 | Prescale exponent N; the divide factor is 2^N |
| center_en | input | 1 | 1 selects up/down counting; 0 selects up-count-and-wrap |
| modulo | input | 16 | Terminal count; 0 means 0xFFFF |
| count_wr | input | 1 | Write strobe that clears the count and the prescaler |
| count | output | 16 | Current count |
| tick | output | 1 | One-cycle pulse for each advance |
| top_hit | output | 1 | One-cycle pulse on the terminal-1 to terminal step |
| overflow | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
The prescaler's state is not visible at the ports. It shows up as tick spacing, so a slipped prescale counter moves the next tick by at least one cycle within one prescale period. A wrong direction bit or terminal decode shows at the very next tick, as a count that steps the wrong way or a `top_hit` or `overflow` pulse in the wrong cycle. The bench compares every output against an independent model in every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } mt_dir_e;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int DIV_SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 clear,
  output logic                 adv
);
  localparam int PS_W = (1 << DIV_SEL_W) - 1;

  logic [PS_W-1:0] ps_q;
  logic [PS_W:0]   one_hot;
  logic [PS_W:0]   mask_w;
  logic [PS_W-1:0] mask;

  always_comb begin
    one_hot = (PS_W+1)'(1) << div_sel;
    mask_w  = one_hot - 1'b1;
    mask    = mask_w[PS_W-1:0];
    adv     = enable && (ps_q == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
    end else if (clear) begin
      ps_q <= '0;
    end else if (enable) begin
      ps_q <= adv ? '0 : ps_q + 1'b1;
    end
  end

  AST_PS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(enable) && !$past(clear)) |-> (ps_q == $past(ps_q))); // R2

  AST_PS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> (ps_q == '0)); // R10
endmodule

// File: rtl/mt_counter.sv
module mt_counter
  import mt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clear,
  input  logic             center,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             hit,
  output logic             ovf
);
  logic [CNT_W-1:0] count_q, nxt, top_val;
  mt_dir_e          dir_q;
  logic             step_down, hit_c, ovf_c;
  logic             tick_q, hit_q, ovf_q;

  always_comb begin
    top_val = (modulo == '0) ? '1 : modulo;
    if (center) begin
      step_down = (dir_q == DIR_DOWN) ? (count_q != '0) : (count_q >= top_val);
      nxt       = step_down ? count_q - 1'b1 : count_q + 1'b1;
      ovf_c     = step_down && (count_q == CNT_W'(1));
    end else begin
      step_down = 1'b0;
      ovf_c     = (count_q == top_val);
      nxt       = ovf_c ? '0 : count_q + 1'b1;
    end
    hit_c = !step_down && (count_q == top_val - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      dir_q   <= DIR_UP;
      tick_q  <= 1'b0;
      hit_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (clear) begin
      count_q <= '0;
      dir_q   <= DIR_UP;
      tick_q  <= 1'b0;
      hit_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      tick_q <= adv;
      hit_q  <= adv && hit_c;
      ovf_q  <= adv && ovf_c;
      if (adv) begin
        count_q <= nxt;
        dir_q   <= step_down ? DIR_DOWN : DIR_UP;
      end
    end
  end

  assign count = count_q;
  assign tick  = tick_q;
  assign hit   = hit_q;
  assign ovf   = ovf_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_q && !$past(clear)) |-> (count_q == $past(count_q))); // R3

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && !$past(center) && !$past(clear))
      |-> (count_q == CNT_W'($past(count_q) + 1'b1) || count_q == '0)); // R4

  AST_CENTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && $past(center) && !$past(clear))
      |-> (count_q == CNT_W'($past(count_q) + 1'b1) ||
           count_q == CNT_W'($past(count_q) - 1'b1))); // R6

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (count_q == '0)); // R5

  AST_HIT_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> (count_q == $past(top_val))); // R8
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top #(
  parameter int CNT_W     = 16,
  parameter int DIV_SEL_W = 3,
  parameter int CSEL_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CSEL_W-1:0]    clk_sel,
  input  logic [DIV_SEL_W-1:0] div_sel,
  input  logic                 center_en,
  input  logic [CNT_W-1:0]     modulo,
  input  logic                 count_wr,
  output logic [CNT_W-1:0]     count,
  output logic                 tick,
  output logic                 top_hit,
  output logic                 overflow
);
  logic run_en;
  logic adv;

  assign run_en = (clk_sel != '0);

  mt_prescaler #(.DIV_SEL_W(DIV_SEL_W)) i_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (run_en),
    .div_sel (div_sel),
    .clear   (count_wr),
    .adv     (adv)
  );

  mt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (adv),
    .clear  (count_wr),
    .center (center_en),
    .modulo (modulo),
    .count  (count),
    .tick   (tick),
    .hit    (top_hit),
    .ovf    (overflow)
  );

  AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_sel) == '0) |-> !tick); // R2

  AST_EVENTS_NEED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (top_hit || overflow) |-> tick); // R8
endmodule

// File: tb/test_modtmr_top.sv
module test_modtmr_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  clk_sel;
  logic [2:0]  div_sel;
  logic        center_en;
  logic [15:0] modulo;
  logic        count_wr;
  logic [15:0] count;
  logic        tick, top_hit, overflow;

  always #5 clk = ~clk;

  modtmr_top i_modtmr_top (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .div_sel(div_sel),
    .center_en(center_en), .modulo(modulo), .count_wr(count_wr),
    .count(count), .tick(tick), .top_hit(top_hit), .overflow(overflow)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit saw_tick = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] pmask(input logic [2:0] n);
    return 7'((8'd1 << n) - 8'd1);
  endfunction

  function automatic logic [15:0] eff_top(input logic [15:0] m);
    return (m == 16'd0) ? 16'hFFFF : m;
  endfunction

  // independent reference model of the requirements
  logic [15:0] m_cnt;
  logic [6:0]  m_ps;
  bit          m_down, m_tick, m_hit, m_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_ps = '0; m_down = 0; m_tick = 0; m_hit = 0; m_ovf = 0;
    end else if (count_wr) begin
      m_cnt = '0; m_ps = '0; m_down = 0; m_tick = 0; m_hit = 0; m_ovf = 0;
    end else begin
      logic        go, dn;
      logic [15:0] t;
      go = (clk_sel != 2'b00) && (m_ps == pmask(div_sel));
      if (clk_sel != 2'b00) m_ps = go ? 7'd0 : m_ps + 7'd1;
      m_tick = go; m_hit = 0; m_ovf = 0;
      if (go) begin
        t = eff_top(modulo);
        if (center_en) begin
          dn = m_down ? (m_cnt != 0) : (m_cnt >= t);
          m_hit = !dn && (m_cnt == t - 16'd1);
          m_ovf = dn && (m_cnt == 16'd1);
          m_cnt = dn ? m_cnt - 16'd1 : m_cnt + 16'd1;
          m_down = dn;
        end else begin
          m_hit = (m_cnt == t - 16'd1);
          m_ovf = (m_cnt == t);
          m_cnt = m_ovf ? 16'd0 : m_cnt + 16'd1;
          m_down = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (tick) saw_tick = 1'b1;
    if (cmp_on) begin
      check(center_en ? "R6 count" : "R4 count", count, m_cnt);
      check("R3 tick", tick, m_tick);
      check("R8 top_hit", top_hit, m_hit);
      check(center_en ? "R7 overflow" : "R5 overflow", overflow, m_ovf);
    end
  end

  task automatic clear_count();
    count_wr = 1'b1;
    @(negedge clk);
    count_wr = 1'b0;
  endtask

  initial begin
    #(64'd1_900_000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; clk_sel = 0; div_sel = 0; center_en = 0; modulo = 16'd10; count_wr = 0;
    repeat (3) @(negedge clk);
    check("R1 count", count, 16'd0);
    check("R1 tick", tick, 0);
    check("R1 top_hit", top_hit, 0);
    check("R1 overflow", overflow, 0);
    rst_n = 1;
    cmp_on = 1;

    // R2: stopped clock select
    saw_tick = 0;
    repeat (40) @(negedge clk);
    check("R2 count held", count, 16'd0);
    check("R2 no tick", saw_tick, 0);

    // R3 / R10: period of 2^3 after a counter write
    clk_sel = 2'b10; div_sel = 3'd3;
    repeat (5) @(negedge clk);
    clear_count();
    check("R10 count cleared", count, 16'd0);
    begin
      int n = 0;
      while (!tick && n < 50) begin @(negedge clk); n++; end
      check("R3 R10 cycles to first tick", n, 8);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick && n < 50);
      check("R3 tick spacing", n, 8);
    end

    // R6 / R7: center mode with terminal 3
    clk_sel = 2'b01; div_sel = 0; center_en = 1; modulo = 16'd3;
    clear_count();
    begin
      logic [15:0] exp_seq [8] = '{1, 2, 3, 2, 1, 0, 1, 2};
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        check("R6 center sequence", count, exp_seq[i]);
        check("R7 overflow at bottom", overflow, (exp_seq[i] == 0));
        check("R8 hit at top", top_hit, (i == 2));
      end
    end

    // R9 / R5: free running over the full range
    center_en = 0; modulo = 16'd0; clk_sel = 2'b11;
    clear_count();
    begin
      int n = 0;
      while (count != 16'hFFFE && n < 70000) begin @(negedge clk); n++; end
      @(negedge clk);
      check("R9 reaches FFFF", count, 16'hFFFF);
      check("R9 hit FFFE->FFFF", top_hit, 1);
      @(negedge clk);
      check("R5 wrap to zero", count, 16'd0);
      check("R5 overflow on wrap", overflow, 1);
    end

    // random segments
    for (int seg = 0; seg < 120; seg++) begin
      clk_sel   = 2'($urandom % 4);
      div_sel   = ($urandom % 8 == 0) ? 3'd7 : 3'($urandom % 4);
      center_en = 1'($urandom % 2);
      modulo    = ($urandom % 10 == 0) ? 16'd0 : 16'(1 + $urandom % 30);
      if ($urandom % 2 == 0) clear_count();
      for (int c = 0; c < 150; c++) begin
        count_wr = ($urandom % 97 == 0);
        @(negedge clk);
      end
      count_wr = 0;
    end

    cmp_on = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule